// File: doc/BRIEF.md
# Serial Fuse Word Programming Sequencer

This block burns one word into a one-time-programmable fuse array, one bit at a time. A start pulse captures the target word address, the requested data and a packed timing word. The sequencer first pulses a read strobe on the array and clears from the captured data every bit that is already blown, so no fuse receives a second program pulse. It then walks the word from bit 0 upward. A bit holding 0 costs a single cycle and draws no strobe. A bit holding 1 gets a relax gap, a program strobe, and a second relax gap. Each of these widths comes from a field of the timing word.

The data register shifts right with zero fill after each bit and is visible on `shift_q`. The request inputs are not sampled again until the sequencer is idle. After the last bit a one-cycle `done` pulse is raised. `busy` stays high through a postamble gap of fixed length, so that the next array operation keeps the required spacing after a write.

Top module: `fuse_prog_seq`

## Requirements
- R1: After a `start` accepted while idle, `busy` and `fuse_rd` are high for exactly RD+1 cycles, where RD is `timing[21:16]`. `fuse_rd` is never high together with `fuse_prog`.
- R2: At the last read cycle the captured data is ANDed with the inverse of `fuse_rdata`. Bits already set in the fuse word are never strobed.
- R3: A bit position holding 1 after masking receives exactly one program strobe. A position holding 0 takes one cycle and receives no strobe.
- R4: The data register shifts right by one with a 0 entering at the MSB after each bit is handled. Changes on `wdata` while busy have no effect on it.
- R5: For each programmed bit, `fuse_prog` is high for PG+1 cycles, where PG is `timing[11:0]`. It is preceded and followed by RL+1 cycles with no strobe, where RL is `timing[15:12]`.
- R6: Bits are handled from index 0 (LSB) to index 31. `fuse_bit` holds the index and `fuse_addr` the captured address throughout each strobe.
- R7: `done` is high for one cycle, the cycle after the last bit is finished. `busy` then stays high for GAP_CYCLES cycles in total, counted from that cycle, and falls afterwards.
- R8: A `start` that arrives while `busy` is high is ignored, and the captured address does not change.
- R9: Reset (synchronous, active high) leaves `busy`, `done`, `fuse_rd` and `fuse_prog` low and clears `shift_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, accepted only when idle |
| wdata | input | DATA_W | Word to program |
| addr | input | ADDR_W | Target fuse word address |
| timing | input | 32 | Program strobe [11:0], relax [15:12], read strobe [21:16] |
| fuse_rdata | input | DATA_W | Current contents of the addressed fuse word |
| fuse_addr | output | ADDR_W | Captured word address |
| fuse_bit | output | $clog2(DATA_W) | Index of the bit being handled |
| fuse_rd | output | 1 | Array read strobe |
| fuse_prog | output | 1 | Array program strobe |
| busy | output | 1 | Operation in progress, including postamble |
| done | output | 1 | One-cycle pulse after the last bit |
| shift_q | output | DATA_W | Data register contents |

## Verification
All outputs decode directly from registered state, so every effect of a start sampled at edge k first shows in the cycle that follows k. From that cycle the bench builds the complete expected trace from the requirements: RD+1 read cycles, then per bit one cycle plus RL+1, PG+1 and RL+1 cycles for each masked 1, then the GAP_CYCLES postamble with `done` in its first cycle. It pops one entry of this trace at every falling edge and compares it with the ports, so a strobe that is one cycle early or late shows up as a mismatch in that cycle. The fuse array contents are checked against the OR of all requested words at the end.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

    localparam int PROG_FW  = 12;
    localparam int RELAX_FW = 4;
    localparam int READ_FW  = 6;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_READ,
        SQ_BIT,
        SQ_PRE,
        SQ_STRB,
        SQ_POST,
        SQ_GAP
    } sq_state_e;

    typedef struct packed {
        logic [READ_FW-1:0]  rd_w;
        logic [RELAX_FW-1:0] relax_w;
        logic [PROG_FW-1:0]  prog_w;
    } sq_timing_t;

    function automatic sq_timing_t unpack_timing(input logic [31:0] raw);
        sq_timing_t t;
        t.prog_w  = raw[11:0];
        t.relax_w = raw[15:12];
        t.rd_w    = raw[21:16];
        return t;
    endfunction

endpackage

// File: rtl/fsq_timer.sv
module fsq_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    // R5
    timer_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/fsq_shifter.sv
module fsq_shifter #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  logic              capture,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] addr,
    input  logic              mask_en,
    input  logic [DATA_W-1:0] mask_word,
    input  logic              shift_en,
    output logic [DATA_W-1:0] data_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [IDX_W-1:0]  idx_q,
    output logic              lsb,
    output logic              last
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            addr_q <= '0;
            idx_q  <= '0;
        end else if (capture) begin
            data_q <= wdata;
            addr_q <= addr;
            idx_q  <= '0;
        end else if (mask_en) begin
            data_q <= data_q & ~mask_word;
        end else if (shift_en) begin
            data_q <= {1'b0, data_q[DATA_W-1:1]};
            idx_q  <= idx_q + 1'b1;
        end
    end

    assign lsb  = data_q[0];
    assign last = (idx_q == IDX_W'(DATA_W - 1));

    // R4
    zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (data_q[DATA_W-1] == 1'b0));

    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(addr_q));

endmodule

// File: rtl/fsq_ctrl.sv
module fsq_ctrl
    import fsq_pkg::*;
#(
    parameter int CNT_W      = 12,
    parameter int GAP_CYCLES = 400
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [31:0]      timing,
    input  logic             lsb,
    input  logic             last,
    input  logic             tmr_zero,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             capture,
    output logic             mask_en,
    output logic             shift_en,
    output logic             busy,
    output logic             fuse_rd,
    output logic             fuse_prog,
    output logic             done
);
    sq_state_e  st_q, st_d;
    sq_timing_t tmg_q, tmg_in;
    logic       enter_gap;
    logic       done_q;

    assign tmg_in = unpack_timing(timing);

    always_comb begin
        st_d      = st_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        capture   = 1'b0;
        mask_en   = 1'b0;
        shift_en  = 1'b0;
        enter_gap = 1'b0;
        case (st_q)
            SQ_IDLE: if (start) begin
                st_d     = SQ_READ;
                capture  = 1'b1;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(tmg_in.rd_w);
            end
            SQ_READ: if (tmr_zero) begin
                mask_en = 1'b1;
                st_d    = SQ_BIT;
            end
            SQ_BIT: begin
                if (lsb) begin
                    st_d     = SQ_PRE;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(tmg_q.relax_w);
                end else begin
                    shift_en = 1'b1;
                    if (last) begin
                        st_d      = SQ_GAP;
                        enter_gap = 1'b1;
                        tmr_load  = 1'b1;
                        tmr_val   = CNT_W'(GAP_CYCLES - 1);
                    end
                end
            end
            SQ_PRE: if (tmr_zero) begin
                st_d     = SQ_STRB;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(tmg_q.prog_w);
            end
            SQ_STRB: if (tmr_zero) begin
                st_d     = SQ_POST;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(tmg_q.relax_w);
            end
            SQ_POST: if (tmr_zero) begin
                shift_en = 1'b1;
                if (last) begin
                    st_d      = SQ_GAP;
                    enter_gap = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = CNT_W'(GAP_CYCLES - 1);
                end else begin
                    st_d = SQ_BIT;
                end
            end
            SQ_GAP: if (tmr_zero) st_d = SQ_IDLE;
            default: st_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SQ_IDLE;
            tmg_q  <= '0;
            done_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            done_q <= enter_gap;
            if (capture) tmg_q <= tmg_in;
        end
    end

    assign busy      = (st_q != SQ_IDLE);
    assign fuse_rd   = (st_q == SQ_READ);
    assign fuse_prog = (st_q == SQ_STRB);
    assign done      = done_q;

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    done_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    // R1
    rd_prog_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(fuse_rd && fuse_prog));

    // R8
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !done && !fuse_rd && start) |=> !fuse_rd);

endmodule

// File: rtl/fuse_prog_seq.sv
module fuse_prog_seq
    import fsq_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 8,
    parameter int GAP_CYCLES = 400,
    localparam int IDX_W     = $clog2(DATA_W),
    localparam int GAP_W     = $clog2(GAP_CYCLES + 1),
    localparam int CNT_W     = (GAP_W > PROG_FW) ? GAP_W : PROG_FW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       timing,
    input  logic [DATA_W-1:0] fuse_rdata,
    output logic [ADDR_W-1:0] fuse_addr,
    output logic [IDX_W-1:0]  fuse_bit,
    output logic              fuse_rd,
    output logic              fuse_prog,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] shift_q
);
    logic             tmr_load, tmr_zero;
    logic [CNT_W-1:0] tmr_val;
    logic             capture, mask_en, shift_en;
    logic             lsb, last;

    fsq_ctrl #(.CNT_W(CNT_W), .GAP_CYCLES(GAP_CYCLES)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .timing(timing),
        .lsb(lsb), .last(last), .tmr_zero(tmr_zero),
        .tmr_load(tmr_load), .tmr_val(tmr_val),
        .capture(capture), .mask_en(mask_en), .shift_en(shift_en),
        .busy(busy), .fuse_rd(fuse_rd), .fuse_prog(fuse_prog), .done(done)
    );

    fsq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    fsq_shifter #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_shift (
        .clk(clk), .rst(rst), .busy(busy), .capture(capture),
        .wdata(wdata), .addr(addr), .mask_en(mask_en), .mask_word(fuse_rdata),
        .shift_en(shift_en), .data_q(shift_q), .addr_q(fuse_addr),
        .idx_q(fuse_bit), .lsb(lsb), .last(last)
    );

    // R3
    prog_on_one_chk: assert property (@(posedge clk) disable iff (rst)
        fuse_prog |-> shift_q[0]);

    // R6
    strobe_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (fuse_prog && $past(fuse_prog)) |-> $stable(fuse_bit));

endmodule

// File: tb/fuse_prog_seq_test.sv
`timescale 1ns/100ps
module fuse_prog_seq_test;
    localparam int DW  = 32;
    localparam int AW  = 4;
    localparam int GAP = 12;

    typedef struct packed {
        logic        busy;
        logic        rd;
        logic        prog;
        logic        done;
        logic [4:0]  bit_i;
        logic [31:0] sh;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   timing = '0;
    logic [DW-1:0] fuse_rdata;
    logic [AW-1:0] fuse_addr;
    logic [4:0]    fuse_bit;
    logic          fuse_rd, fuse_prog, busy, done;
    logic [DW-1:0] shift_q;

    logic [31:0] fmem  [16];
    logic [31:0] efuse [16];
    exp_t        q[$];
    logic [AW-1:0] cur_addr;
    int ncmp = 0;
    int nbad = 0;

    always #2.5 clk = ~clk;

    fuse_prog_seq #(.DATA_W(DW), .ADDR_W(AW), .GAP_CYCLES(GAP)) uut (
        .clk(clk), .rst(rst), .start(start), .wdata(wdata), .addr(addr),
        .timing(timing), .fuse_rdata(fuse_rdata), .fuse_addr(fuse_addr),
        .fuse_bit(fuse_bit), .fuse_rd(fuse_rd), .fuse_prog(fuse_prog),
        .busy(busy), .done(done), .shift_q(shift_q)
    );

    assign fuse_rdata = fmem[fuse_addr];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 16; i++) fmem[i] <= '0;
        end else if (fuse_prog) begin
            fmem[fuse_addr][fuse_bit] <= 1'b1;
        end
    end

    task automatic push(input logic b, input logic r, input logic p,
                        input logic d, input int bi, input logic [31:0] s);
        exp_t e;
        e.busy = b; e.rd = r; e.prog = p; e.done = d;
        e.bit_i = 5'(bi); e.sh = s;
        q.push_back(e);
    endtask

    task automatic plan_op(input logic [AW-1:0] a, input logic [31:0] w,
                           input int pg, input int rl, input int rdw);
        logic [31:0] m;
        m = w & ~fmem[a];
        for (int k = 0; k <= rdw; k++) push(1, 1, 0, 0, 0, w);
        for (int i = 0; i < 32; i++) begin
            push(1, 0, 0, 0, 0, m >> i);
            if (m[i]) begin
                for (int k = 0; k <= rl; k++) push(1, 0, 0, 0, 0, m >> i);
                for (int k = 0; k <= pg; k++) push(1, 0, 1, 0, i, m >> i);
                for (int k = 0; k <= rl; k++) push(1, 0, 0, 0, 0, m >> i);
            end
        end
        for (int k = 0; k < GAP; k++) push(1, 0, 0, (k == 0), 0, 32'h0);
        efuse[a] = efuse[a] | w;
    endtask

    task automatic tick();
        exp_t e;
        @(negedge clk);
        ncmp++;
        if (q.size() > 0) e = q.pop_front();
        else e = '0;
        if (busy !== e.busy) begin
            nbad++; $display("FAIL R7 busy act=%0b exp=%0b t=%0t", busy, e.busy, $time);
        end else if (fuse_rd !== e.rd) begin
            nbad++; $display("FAIL R1 fuse_rd act=%0b exp=%0b t=%0t", fuse_rd, e.rd, $time);
        end else if (fuse_prog !== e.prog) begin
            nbad++; $display("FAIL R5 fuse_prog act=%0b exp=%0b t=%0t", fuse_prog, e.prog, $time);
        end else if (done !== e.done) begin
            nbad++; $display("FAIL R7 done act=%0b exp=%0b t=%0t", done, e.done, $time);
        end else if (e.busy && shift_q !== e.sh) begin
            nbad++; $display("FAIL R4 shift_q act=%h exp=%h t=%0t", shift_q, e.sh, $time);
        end else if (e.prog && fuse_bit !== e.bit_i) begin
            nbad++; $display("FAIL R6 fuse_bit act=%0d exp=%0d t=%0t", fuse_bit, e.bit_i, $time);
        end else if (e.prog && fuse_addr !== cur_addr) begin
            nbad++; $display("FAIL R8 fuse_addr act=%0d exp=%0d t=%0t", fuse_addr, cur_addr, $time);
        end
    endtask

    // poke: drive a second request and new data while busy (R8, R4)
    task automatic run_op(input logic [AW-1:0] a, input logic [31:0] w,
                          input int pg, input int rl, input int rdw, input bit poke);
        plan_op(a, w, pg, rl, rdw);
        cur_addr = a;
        addr   = a;
        wdata  = w;
        timing = {10'd0, 6'(rdw), 4'(rl), 12'(pg)};
        start  = 1'b1;
        tick();
        start  = 1'b0;
        if (poke) begin
            for (int k = 0; k < 40; k++) begin
                start = (k % 7 == 3);
                wdata = ~w;
                addr  = a + 4'd1;
                timing = 32'h003F_FFFF;
                tick();
            end
            start = 1'b0;
        end
        while (q.size() > 0) tick();
        tick();
    endtask

    initial begin
        for (int i = 0; i < 16; i++) efuse[i] = '0;
        cur_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        ncmp++;
        // R9 reset state
        if (busy !== 1'b0 || done !== 1'b0 || fuse_rd !== 1'b0 ||
            fuse_prog !== 1'b0 || shift_q !== '0) begin
            nbad++;
            $display("FAIL R9 reset act=%b%b%b%b %h exp=0000 0", busy, done, fuse_rd, fuse_prog, shift_q);
        end
        rst = 1'b0;
        tick();
        // R1 R3 R5 R6: two ones, zeros skipped
        run_op(4'd3, 32'h0000_0005, 2, 1, 3, 0);
        // R2: bits 0 and 2 already blown, only 1 and 3 strobed
        run_op(4'd3, 32'h0000_000F, 3, 2, 1, 0);
        // R2: everything already blown, no strobe at all
        run_op(4'd3, 32'h0000_000F, 3, 2, 1, 0);
        // R5 R6 R7: minimum widths, last bit is 31
        run_op(4'd5, 32'h8000_0001, 0, 0, 0, 0);
        // R3: all-zero word
        run_op(4'd7, 32'h0000_0000, 1, 1, 2, 0);
        // R4 R8: dense word with stray request and data changes while busy
        run_op(4'd9, 32'hFFFF_FFFF, 1, 0, 2, 1);
        // R4 R8: sparse word with stray request
        run_op(4'd12, 32'h0123_4000, 4, 3, 5, 1);
        // R2: final fuse contents
        for (int i = 0; i < 16; i++) begin
            ncmp++;
            if (fmem[i] !== efuse[i]) begin
                nbad++;
                $display("FAIL R2 fuse word %0d act=%h exp=%h", i, fmem[i], efuse[i]);
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        ncmp++;
        nbad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
        $finish;
    end

endmodule